// File: doc/BRIEF.md
# Card Bus Clock Generator with Flow-Control Stall

This block derives the clock for a memory-card bus from the peripheral clock. A programmable divider sets the card clock to the peripheral clock divided by an even number from 2 to 512. Alongside the card clock it produces a one-cycle enable pulse on every rising edge, so that the command and data shift logic can run in the peripheral clock domain.

Software starts and stops the clock with one-cycle enable and disable strobes. A software-reset strobe returns the block to its idle state, and an enable must follow before the clock runs again. Two mode bits can freeze the card clock when the data path cannot keep up. With the read-proof bit set, a receive transfer pauses while the receive holding register is full. With the write-proof bit set, a transmit transfer pauses while the transmit holding register is empty. A paused clock holds its level and its position in the phase, so no data is overrun or underrun.

A divider value written while the clock runs is taken over only at a falling edge, which is the end of a full card-clock period. The high phase in progress therefore always finishes at its old length.

Top module: `cardClkGen`

## Requirements
- R1: After reset, cardClk and shiftEn are low. They stay low until an enable strobe is given, whatever modeReg holds.
- R2: The divider D is modeReg[7:0]. Each high phase and each low phase lasts D+1 peripheral cycles, so the period is 2(D+1): 2 cycles for D=0 and 512 cycles for D=255.
- R3: After an enable strobe from the stopped state, cardClk first rises on the (D+2)th peripheral clock edge, counting as the first the edge that samples the strobe. The clock always starts with a low phase.
- R4: shiftEn is high for exactly one peripheral cycle, in the same cycle that cardClk goes high, and at no other time.
- R5: A new divider value written while the clock runs is loaded at the next falling edge of cardClk. The high phase in progress keeps the old length and the following low phase uses the new one. While the clock is stopped, the divider follows modeReg directly.
- R6: When read-proof (modeReg[8]) is set, xferRead is 1 and rxFull is 1, cardClk holds its level and shiftEn stays low. When rxFull clears, the phase resumes with the cycles it had left.
- R7: When write-proof (modeReg[9]) is set, xferRead is 0 and txEmpty is 1, cardClk holds its level and shiftEn stays low.
- R8: rxFull is ignored when read-proof is clear or xferRead is 0. txEmpty is ignored when write-proof is clear or xferRead is 1. In those cases the clock keeps its normal period.
- R9: A disable strobe stops the clock. From the second edge after the strobe, cardClk is low and shiftEn stays low until the next enable.
- R10: A software-reset strobe stops the clock in the same way, and the clock stays stopped until a later enable. When strobes coincide, software reset takes priority over disable, and disable takes priority over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| modeReg | input | 16 | Mode value: [7:0] divider, [8] read-proof, [9] write-proof |
| enableStb | input | 1 | One-cycle strobe that starts the card clock |
| disableStb | input | 1 | One-cycle strobe that stops the card clock |
| swResetStb | input | 1 | One-cycle software reset strobe |
| rxFull | input | 1 | Receive holding register is full and unread |
| txEmpty | input | 1 | Transmit holding register is empty |
| xferRead | input | 1 | 1 for a receive transfer, 0 for a transmit transfer |
| cardClk | output | 1 | Card bus clock |
| shiftEn | output | 1 | One-cycle pulse at each cardClk rising edge |

## Verification
Every output is a register. Start, stop and proof-bit changes therefore show one edge after the strobe is sampled. The first rising edge is due D+1 edges after that, and each phase then lasts D+1 cycles. The bench drives all inputs on the falling edge of clk and samples on the falling edge. It measures each phase as the number of falling edges between two level changes of cardClk, so each expected value is D+1 with no offset. For a stall, the bench checks that the level is frozen on every sample, and then that the phase finishes with exactly the cycles it had left. For the stop tests, the bench skips the two samples in which a pulse that is already under way may still finish, and then requires silence.

// File: rtl/cardClkPkg.sv
package cardClkPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic run;   // clock enabled
    logic hold;  // freeze phase counter and level this cycle
  } clkStrobe_t;
endpackage

// File: rtl/cardClkCtrl.sv
module cardClkCtrl
  import cardClkPkg::*;
#(
  parameter int MODE_W       = 16,
  parameter int RD_PROOF_BIT = 8,
  parameter int WR_PROOF_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReg,
  input  logic              enableStb,
  input  logic              disableStb,
  input  logic              swResetStb,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              xferRead,
  output clkStrobe_t        strobes
);
  logic running;
  logic rdProof;
  logic wrProof;
  logic rxStall;
  logic txStall;

  // Software reset wins over disable, disable wins over enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      rdProof <= 1'b0;
      wrProof <= 1'b0;
    end else if (swResetStb) begin
      running <= 1'b0;
      rdProof <= 1'b0;
      wrProof <= 1'b0;
    end else begin
      rdProof <= modeReg[RD_PROOF_BIT];
      wrProof <= modeReg[WR_PROOF_BIT];
      if (disableStb)
        running <= 1'b0;
      else if (enableStb)
        running <= 1'b1;
    end
  end

  // Flow-control stall, gated by direction and proof bits
  always_comb begin
    rxStall = rdProof &&  xferRead && rxFull;
    txStall = wrProof && !xferRead && txEmpty;
  end

  assign strobes.run  = running;
  assign strobes.hold = running && (rxStall || txStall);

  // R10: the clock only starts on an enable that nothing outranks
  a_r10_start_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(enableStb && !disableStb && !swResetStb));

  // R9: a disable or software reset always leaves the block stopped
  a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    (disableStb || swResetStb) |=> !strobes.run);
endmodule

// File: rtl/cardClkDp.sv
module cardClkDp
  import cardClkPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] modeDiv,
  input  clkStrobe_t       strobes,
  output logic             cardClk,
  output logic             shiftEn
);
  localparam int CNT_W = DIV_W;

  logic [CNT_W-1:0] phaseCnt;
  logic [DIV_W-1:0] activeDiv;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == activeDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      activeDiv <= '0;
      cardClk   <= 1'b0;
      shiftEn   <= 1'b0;
    end else if (!strobes.run) begin
      // stopped: park low, track the divider directly
      phaseCnt  <= '0;
      activeDiv <= modeDiv;
      cardClk   <= 1'b0;
      shiftEn   <= 1'b0;
    end else if (strobes.hold) begin
      shiftEn   <= 1'b0;
    end else if (phaseEnd) begin
      phaseCnt  <= '0;
      cardClk   <= ~cardClk;
      shiftEn   <= ~cardClk;
      // falling edge closes a full period: safe point for a new divider
      if (cardClk)
        activeDiv <= modeDiv;
    end else begin
      phaseCnt  <= phaseCnt + 1'b1;
      shiftEn   <= 1'b0;
    end
  end

  // R4: the shift pulse lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> !shiftEn);

  // R4: every rise of the card clock carries a shift pulse
  a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardClk) |-> shiftEn);

  // R6 / R7: a stall freezes the level and suppresses the pulse
  a_r6_stall_freezes: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> ($stable(cardClk) && !shiftEn));

  // R9: a stopped clock sits low
  a_r9_stopped_low: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> !cardClk);

  // R5: the divider changes only at a falling edge or while stopped
  a_r5_div_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeDiv) |-> ($fell(cardClk) || !$past(strobes.run)));
endmodule

// File: rtl/cardClkGen.sv
module cardClkGen
  import cardClkPkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int MODE_W       = 16,
  parameter int RD_PROOF_BIT = 8,
  parameter int WR_PROOF_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReg,
  input  logic              enableStb,
  input  logic              disableStb,
  input  logic              swResetStb,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              xferRead,
  output logic              cardClk,
  output logic              shiftEn
);
  clkStrobe_t strobes;

  cardClkCtrl #(
    .MODE_W      (MODE_W),
    .RD_PROOF_BIT(RD_PROOF_BIT),
    .WR_PROOF_BIT(WR_PROOF_BIT)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeReg   (modeReg),
    .enableStb (enableStb),
    .disableStb(disableStb),
    .swResetStb(swResetStb),
    .rxFull    (rxFull),
    .txEmpty   (txEmpty),
    .xferRead  (xferRead),
    .strobes   (strobes)
  );

  cardClkDp #(
    .DIV_W(DIV_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .modeDiv(modeReg[DIV_W-1:0]),
    .strobes(strobes),
    .cardClk(cardClk),
    .shiftEn(shiftEn)
  );
endmodule

// File: tb/tb_cardClkGen.sv
`timescale 1ns/1ps
module tb_cardClkGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] modeReg = '0;
  logic        enableStb = 1'b0;
  logic        disableStb = 1'b0;
  logic        swResetStb = 1'b0;
  logic        rxFull = 1'b0;
  logic        txEmpty = 1'b0;
  logic        xferRead = 1'b0;
  logic        cardClk;
  logic        shiftEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  cardClkGen dut (
    .clk(clk), .rstN(rstN), .modeReg(modeReg),
    .enableStb(enableStb), .disableStb(disableStb), .swResetStb(swResetStb),
    .rxFull(rxFull), .txEmpty(txEmpty), .xferRead(xferRead),
    .cardClk(cardClk), .shiftEn(shiftEn)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] mkMode(input int div, input bit rd, input bit wr);
    return {6'b0, wr, rd, 8'(div)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit en, input bit dis, input bit sw);
    enableStb = en; disableStb = dis; swResetStb = sw;
    @(negedge clk);
    enableStb = 1'b0; disableStb = 1'b0; swResetStb = 1'b0;
  endtask

  // waits until shiftEn is seen; returns 1 if found
  task automatic waitRise(output bit found);
    found = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (shiftEn) begin found = 1'b1; break; end
    end
  endtask

  // cycles until cardClk changes level
  task automatic halfPhase(output int n);
    logic prev;
    prev = cardClk;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cardClk == prev && n < 2000);
  endtask

  // no activity after the settle window
  task automatic checkIdle(input string tag, input int len);
    int bad = 0;
    cyc(2);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (cardClk || shiftEn) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic startClock(input logic [15:0] m);
    pulse(1'b0, 1'b1, 1'b0);
    modeReg = m;
    cyc(2);
    pulse(1'b1, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    check(cardClk == 1'b0, "R1 cardClk after reset", cardClk, 0);
    check(shiftEn == 1'b0, "R1 shiftEn after reset", shiftEn, 0);
    modeReg = mkMode(0, 0, 0);
    checkIdle("R1 idle without enable", 20);
  endtask

  task automatic testPeriod(input int d);
    bit f;
    int n;
    startClock(mkMode(d, 0, 0));
    waitRise(f);
    check(f, "R2 clock running", f, 1);
    halfPhase(n);
    check(n == d + 1, "R2 high phase", n, d + 1);
    halfPhase(n);
    check(n == d + 1, "R2 low phase", n, d + 1);
  endtask

  task automatic testPulse();
    bit f;
    startClock(mkMode(3, 0, 0));
    waitRise(f);
    check(cardClk == 1'b1, "R4 cardClk high with pulse", cardClk, 1);
    @(negedge clk);
    check(shiftEn == 1'b0, "R4 pulse one cycle", shiftEn, 0);
  endtask

  task automatic testStart(input int d);
    int k = 0;
    pulse(1'b0, 1'b1, 1'b0);
    modeReg = mkMode(d, 0, 0);
    cyc(3);
    enableStb = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      enableStb = 1'b0;
      k++;
      if (shiftEn) break;
    end
    check(k == d + 2, "R3 first rise latency", k, d + 2);
  endtask

  task automatic testDivChange();
    bit f;
    int n;
    startClock(mkMode(2, 0, 0));
    waitRise(f);
    modeReg = mkMode(5, 0, 0);
    halfPhase(n);
    check(n == 3, "R5 high phase keeps old divider", n, 3);
    halfPhase(n);
    check(n == 6, "R5 low phase uses new divider", n, 6);
    halfPhase(n);
    check(n == 6, "R5 high phase new divider", n, 6);
  endtask

  task automatic testStall(input bit rdSide);
    bit f;
    int n;
    int bad = 0;
    logic lvl;
    string tag;
    tag = rdSide ? "R6" : "R7";
    xferRead = rdSide;
    startClock(mkMode(3, rdSide, !rdSide));
    cyc(2);
    waitRise(f);
    @(negedge clk);
    lvl = cardClk;
    if (rdSide) rxFull = 1'b1; else txEmpty = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cardClk != lvl || shiftEn) bad++;
    end
    check(bad == 0, {tag, " clock frozen"}, bad, 0);
    rxFull = 1'b0; txEmpty = 1'b0;
    halfPhase(n);
    check(n == 3, {tag, " resumes with remaining cycles"}, n, 3);
  endtask

  task automatic testIgnored();
    bit f;
    int n;
    // read-proof set but transmit direction
    xferRead = 1'b0;
    rxFull = 1'b1;
    startClock(mkMode(2, 1, 0));
    cyc(2);
    waitRise(f);
    halfPhase(n);
    check(n == 3, "R8 rxFull ignored in transmit", n, 3);
    halfPhase(n);
    check(n == 3, "R8 rxFull ignored in transmit low", n, 3);
    // no proof bits, both status flags active
    xferRead = 1'b1;
    txEmpty = 1'b1;
    modeReg = mkMode(2, 0, 0);
    cyc(8);
    waitRise(f);
    halfPhase(n);
    check(n == 3, "R8 status ignored without proof bits", n, 3);
    // write-proof set but receive direction
    modeReg = mkMode(2, 0, 1);
    cyc(8);
    waitRise(f);
    halfPhase(n);
    check(n == 3, "R8 txEmpty ignored in receive", n, 3);
    rxFull = 1'b0; txEmpty = 1'b0;
  endtask

  task automatic testDisable();
    bit f;
    startClock(mkMode(1, 0, 0));
    waitRise(f);
    pulse(1'b0, 1'b1, 1'b0);
    checkIdle("R9 disabled clock silent", 30);
    pulse(1'b1, 1'b0, 1'b0);
    waitRise(f);
    check(f, "R9 enable restarts", f, 1);
  endtask

  task automatic testSwReset();
    bit f;
    startClock(mkMode(1, 0, 0));
    waitRise(f);
    pulse(1'b0, 1'b0, 1'b1);
    checkIdle("R10 stopped after software reset", 30);
    pulse(1'b1, 1'b0, 1'b1);
    checkIdle("R10 software reset beats enable", 30);
    pulse(1'b1, 1'b1, 1'b0);
    checkIdle("R10 disable beats enable", 30);
    pulse(1'b1, 1'b0, 1'b0);
    waitRise(f);
    check(f, "R10 enable after software reset", f, 1);
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriod(0);
    testPeriod(3);
    testPeriod(255);
    testPulse();
    testStart(0);
    testStart(4);
    testDivChange();
    testStall(1'b1);
    testStall(1'b0);
    testIgnored();
    testDisable();
    testSwReset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule